// File: doc/BRIEF.md
# Complementary Dead-Time Pair Generator

This block takes one pulse-width signal from an upstream generator and turns it into a complementary pair for the high-side and low-side switches of a single half bridge. While dead time is on, the high-side output copies the source but reaches its active level only after a programmable number of clock cycles. The low-side output copies the inverse of the source, and its turn-on is postponed by a second, independent count. A turn-off always follows the source without extra delay, so the two outputs are never high together. While dead time is off, the generator's own high and low signals pass straight to the outputs.

Three settings are written through a simple write port: the enable flag, the high-side turn-on delay and the low-side turn-on delay. Each write waits in a shadow slot until a shared update policy applies it. The policy can apply it at once, at the next counter-zero strobe, or at the first counter-zero strobe after a global sync request. A second write to the same slot before it is applied replaces the waiting value, and the earlier value is never used. Both outputs are registered, so every change shows one clock after the edge that sampled it.

Top module: `deadtime_pair`

## Requirements
- R1: With dead time on, `out_hi` goes high `rise_dly + 1` cycles after the first clock edge that samples `pwm_a_in` high, provided the source is still high. It goes low one cycle after the first edge that samples the source low. A delay of 0 gives a plain one-cycle copy.
- R2: With dead time on, `out_lo` is the inverse of `pwm_a_in`. It goes high `fall_dly + 1` cycles after the first edge that samples the source low, and goes low one cycle after the source is sampled high.
- R3: The two delays are separate 12-bit cycle counts, written with `wr_sel` = 1 (high-side delay) and `wr_sel` = 2 (low-side delay), and they may differ. `wr_sel` = 0 writes the enable flag from `wr_data[0]`, and `wr_sel` = 3 writes nothing.
- R4: While dead time is on, `out_hi` and `out_lo` are never high in the same cycle.
- R5: With `upd_mode` = 0 (immediate), a write is used from the next clock on. With `upd_mode` = 1 (local), a waiting write is applied at the next clock edge that samples `cnt_zero` high.
- R6: With `upd_mode` = 2 or 3 (global), a waiting write is applied only at a `cnt_zero` edge while a sync request is latched. Counter-zero strobes without a latched request leave it waiting.
- R7: A second write to a slot before the first has been applied replaces the waiting value, and the earlier value never reaches the outputs.
- R8: With dead time off, `out_hi` is `pwm_a_in` and `out_lo` is `pwm_b_in`, each one cycle later, with no delay inserted.
- R9: A one-cycle `gsync_req` is latched. The latch clears at the next `cnt_zero` edge, unless a new request arrives in that same cycle, so a later zero strobe does not apply a newer write.
- R10: A source pulse that stays high (or low) for no more than the relevant delay count produces no pulse on `out_hi` (or `out_lo`).
- R11: During and after reset, dead time is off, both delays are 0 and both outputs are low while reset is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; delays count its cycles |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwm_a_in | input | 1 | Generator's high-side signal, the source for both delayed outputs |
| pwm_b_in | input | 1 | Generator's low-side signal, used only when dead time is off |
| cnt_zero | input | 1 | One-cycle strobe when the generator counter reaches zero |
| gsync_req | input | 1 | One-cycle global sync request |
| upd_mode | input | 2 | Update policy: 0 immediate, 1 local, 2 or 3 global |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 2 | Write target: 0 enable, 1 high-side delay, 2 low-side delay |
| wr_data | input | 12 | Write value |
| out_hi | output | 1 | High-side switch drive |
| out_lo | output | 1 | Low-side switch drive |

## Verification
The bench goes after source pulses exactly as long as a delay count. A design that compares with the wrong bound would let a one-cycle sliver through or swallow a pulse that should survive. It sets the two delays to different values, which exposes a design that swaps them or applies one count to both edges. It writes a slot twice under the local policy and sends counter-zero strobes without a sync request under the global policy. A design that kept the first value, applied writes early, or left the sync latch set would show the wrong pulse widths in the periods that follow.

// File: rtl/dtp_pkg.sv
package dtp_pkg;

  typedef enum logic [1:0] {
    UPD_NOW     = 2'd0,
    UPD_LOCAL   = 2'd1,
    UPD_GLOBAL  = 2'd2,
    UPD_GLOBAL2 = 2'd3
  } upd_mode_e;

  // Decides whether waiting shadow values may move to the active copy this cycle.
  function automatic logic apply_ok(upd_mode_e m, logic zero, logic armed);
    case (m)
      UPD_NOW:   return 1'b1;
      UPD_LOCAL: return zero;
      default:   return zero & armed;
    endcase
  endfunction

endpackage

// File: rtl/dtp_sync.sv
module dtp_sync (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              gsync_req,
  input  logic              cnt_zero,
  input  dtp_pkg::upd_mode_e mode,
  output logic              apply_evt,
  output logic              armed
);

  // Request latch: cleared by a zero strobe, set by a new request (the request wins).
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= (armed & ~cnt_zero) | gsync_req;
  end

  assign apply_evt = dtp_pkg::apply_ok(mode, cnt_zero, armed);

endmodule

// File: rtl/dtp_shadow.sv
module dtp_shadow #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  input  logic         apply,
  output logic [W-1:0] act,
  output logic         pending
);

  logic [W-1:0] pval;
  logic [W-1:0] cand;
  logic         have;

  // A write arriving together with the apply event goes straight through.
  assign cand = wr ? wdata : pval;
  assign have = wr | pending;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act     <= '0;
      pval    <= '0;
      pending <= 1'b0;
    end else if (apply && have) begin
      act     <= cand;
      pending <= 1'b0;
    end else if (wr) begin
      pval    <= wdata;
      pending <= 1'b1;
    end
  end

endmodule

// File: rtl/dtp_edge_delay.sv
module dtp_edge_delay #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         src,
  input  logic [W-1:0] dly,
  output logic         ready
);

  logic [W-1:0] run;

  // Saturating count of earlier consecutive cycles with src high.
  function automatic logic [W-1:0] sat_step(logic [W-1:0] c);
    return (&c) ? c : c + 1'b1;
  endfunction

  function automatic logic held_long(logic [W-1:0] c, logic [W-1:0] d);
    return c >= d;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   run <= '0;
    else if (src) run <= sat_step(run);
    else          run <= '0;
  end

  assign ready = src && held_long(run, dly);

endmodule

// File: rtl/deadtime_pair.sv
module deadtime_pair #(
  parameter int DLY_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pwm_a_in,
  input  logic             pwm_b_in,
  input  logic             cnt_zero,
  input  logic             gsync_req,
  input  logic [1:0]       upd_mode,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [DLY_W-1:0] wr_data,
  output logic             out_hi,
  output logic             out_lo
);

  localparam int N_LANE  = 2;
  localparam int SEL_W   = 2;
  localparam logic [SEL_W-1:0] SEL_EN   = 2'd0;
  localparam logic [SEL_W-1:0] SEL_RISE = 2'd1;
  localparam logic [SEL_W-1:0] SEL_FALL = 2'd2;

  // Named internal events used by the checker.
  logic             apply_evt;
  logic             armed;
  logic             en_act;
  logic [DLY_W-1:0] rise_act;
  logic [DLY_W-1:0] fall_act;
  logic [2:0]       wr_hit;
  logic [2:0]       pend;
  logic [N_LANE-1:0] lane_src;
  logic [N_LANE-1:0] lane_ok;
  logic [DLY_W-1:0] lane_dly [N_LANE];

  assign wr_hit[0] = wr_en && (wr_sel == SEL_EN);
  assign wr_hit[1] = wr_en && (wr_sel == SEL_RISE);
  assign wr_hit[2] = wr_en && (wr_sel == SEL_FALL);

  dtp_sync u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .gsync_req (gsync_req),
    .cnt_zero  (cnt_zero),
    .mode      (dtp_pkg::upd_mode_e'(upd_mode)),
    .apply_evt (apply_evt),
    .armed     (armed)
  );

  dtp_shadow #(.W(1)) u_en (
    .clk (clk), .rst_n (rst_n), .wr (wr_hit[0]), .wdata (wr_data[0]),
    .apply (apply_evt), .act (en_act), .pending (pend[0])
  );

  dtp_shadow #(.W(DLY_W)) u_rise (
    .clk (clk), .rst_n (rst_n), .wr (wr_hit[1]), .wdata (wr_data),
    .apply (apply_evt), .act (rise_act), .pending (pend[1])
  );

  dtp_shadow #(.W(DLY_W)) u_fall (
    .clk (clk), .rst_n (rst_n), .wr (wr_hit[2]), .wdata (wr_data),
    .apply (apply_evt), .act (fall_act), .pending (pend[2])
  );

  // Lane 0 delays the source's turn-on, lane 1 the inverted source's turn-on.
  assign lane_src[0] = pwm_a_in;
  assign lane_src[1] = ~pwm_a_in;
  assign lane_dly[0] = rise_act;
  assign lane_dly[1] = fall_act;

  for (genvar g = 0; g < N_LANE; g++) begin : g_lane
    dtp_edge_delay #(.W(DLY_W)) u_dly (
      .clk   (clk),
      .rst_n (rst_n),
      .src   (lane_src[g]),
      .dly   (lane_dly[g]),
      .ready (lane_ok[g])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_hi <= 1'b0;
      out_lo <= 1'b0;
    end else if (en_act) begin
      out_hi <= lane_ok[0];
      out_lo <= lane_ok[1];
    end else begin
      out_hi <= pwm_a_in;
      out_lo <= pwm_b_in;
    end
  end

endmodule

// File: rtl/deadtime_pair_checker.sv
module deadtime_pair_checker #(
  parameter int DLY_W = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             pwm_a_in,
  input logic             pwm_b_in,
  input logic             cnt_zero,
  input logic             gsync_req,
  input logic [1:0]       upd_mode,
  input logic             wr_en,
  input logic [1:0]       wr_sel,
  input logic [DLY_W-1:0] wr_data,
  input logic             out_hi,
  input logic             out_lo,
  input logic             en_act,
  input logic [DLY_W-1:0] rise_act,
  input logic [DLY_W-1:0] fall_act,
  input logic             armed
);

  AST_HI_FALLS_AT_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    (en_act && !pwm_a_in) |=> !out_hi); // R1

  AST_LO_FALLS_AT_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    (en_act && pwm_a_in) |=> !out_lo); // R2

  AST_NO_SHOOT_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
    en_act |=> !(out_hi && out_lo)); // R4

  AST_IMMEDIATE_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_mode == 2'd0 && wr_en && wr_sel == 2'd1) |=> (rise_act == $past(wr_data))); // R5

  AST_LOCAL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_mode == 2'd1 && !cnt_zero) |=> ($stable(rise_act) && $stable(fall_act) && $stable(en_act))); // R5

  AST_GLOBAL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_mode[1] && !(cnt_zero && armed)) |=> ($stable(rise_act) && $stable(fall_act) && $stable(en_act))); // R6

  AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
    !en_act |=> (out_hi == $past(pwm_a_in) && out_lo == $past(pwm_b_in))); // R8

  AST_SYNC_LATCHES: assert property (@(posedge clk) disable iff (!rst_n)
    gsync_req |=> armed); // R9

  AST_SYNC_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_zero && !gsync_req) |=> !armed); // R9

endmodule

bind deadtime_pair deadtime_pair_checker #(.DLY_W(DLY_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .pwm_a_in  (pwm_a_in),
  .pwm_b_in  (pwm_b_in),
  .cnt_zero  (cnt_zero),
  .gsync_req (gsync_req),
  .upd_mode  (upd_mode),
  .wr_en     (wr_en),
  .wr_sel    (wr_sel),
  .wr_data   (wr_data),
  .out_hi    (out_hi),
  .out_lo    (out_lo),
  .en_act    (en_act),
  .rise_act  (rise_act),
  .fall_act  (fall_act),
  .armed     (armed)
);

// File: tb/deadtime_pair_bench.sv
module deadtime_pair_bench;
  localparam int DW = 12;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          a = 1'b0, b = 1'b0, cz = 1'b0, gs = 1'b0, wr_en = 1'b0;
  logic [1:0]    wr_sel = 2'd0, mode = 2'd0;
  logic [DW-1:0] wr_data = '0;
  logic          oh, ol;

  always #4 clk = ~clk;

  deadtime_pair #(.DLY_W(DW)) u_deadtime_pair (
    .clk (clk), .rst_n (rst_n), .pwm_a_in (a), .pwm_b_in (b),
    .cnt_zero (cz), .gsync_req (gs), .upd_mode (mode),
    .wr_en (wr_en), .wr_sel (wr_sel), .wr_data (wr_data),
    .out_hi (oh), .out_lo (ol)
  );

  int    tests = 0, fails = 0;
  string phase = "R11 reset";

  typedef struct {
    logic  hi;
    logic  lo;
    logic  en;
    string tag;
  } exp_t;
  exp_t q[$];

  task automatic check(bit ok, string tag, string what, int got, int expv);
    tests++;
    if (!ok) begin
      fails++;
      $display("[TB] FAIL %s %s: actual %0d expected %0d", tag, what, got, expv);
    end
  endtask

  // Reference model, written from the requirements: time stamps of source edges.
  longint cyc = 0, t_hi = 0, t_lo = 0;
  bit     first = 1'b1;
  logic   prev_a = 1'b0;
  int     act [3] = '{0, 0, 0};
  int     pv  [3] = '{0, 0, 0};
  bit     pend[3] = '{0, 0, 0};
  bit     armed_m = 1'b0;

  always @(posedge clk) begin
    if (rst_n) begin
      exp_t e;
      bit   ap;
      if (first || a !== prev_a) begin
        if (a) t_hi = cyc;
        else   t_lo = cyc;
      end
      first  = 1'b0;
      prev_a = a;
      e.en  = (act[0] != 0);
      e.hi  = e.en ? (a && ((cyc - t_hi) >= act[1])) : a;
      e.lo  = e.en ? (!a && ((cyc - t_lo) >= act[2])) : b;
      e.tag = phase;
      q.push_back(e);
      if (mode == 2'd0)      ap = 1'b1;
      else if (mode == 2'd1) ap = cz;
      else                   ap = cz && armed_m;
      armed_m = (armed_m && !cz) || gs;
      for (int k = 0; k < 3; k++) begin
        bit hit;
        int val;
        hit = wr_en && (wr_sel == k[1:0]);
        val = (k == 0) ? int'(wr_data[0]) : int'(wr_data);
        if (ap && (hit || pend[k])) begin
          act[k]  = hit ? val : pv[k];
          pend[k] = 1'b0;
        end else if (hit) begin
          pend[k] = 1'b1;
          pv[k]   = val;
        end
      end
      cyc++;
    end
  end

  // Monitor: compares each registered output against the queued expectation.
  always @(negedge clk) begin
    if (rst_n && q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      check(oh === e.hi, e.tag, "out_hi", int'(oh), int'(e.hi));
      check(ol === e.lo, e.tag, "out_lo", int'(ol), int'(e.lo));
      if (e.en) check(!(oh && ol), "R4", "both outputs high", 1, 0);
    end
  end

  task automatic reg_wr(logic [1:0] sel, int val);
    @(negedge clk);
    cz = 1'b0; gs = 1'b0;
    wr_en = 1'b1; wr_sel = sel; wr_data = DW'(val);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic sync_pulse();
    @(negedge clk);
    cz = 1'b0; wr_en = 1'b0; gs = 1'b1;
    @(negedge clk);
    gs = 1'b0;
  endtask

  task automatic period(int hi, int lo, int reps);
    for (int r = 0; r < reps; r++) begin
      for (int i = 0; i < hi + lo; i++) begin
        @(negedge clk);
        a = (i < hi); b = ~a; cz = (i == 0); gs = 1'b0; wr_en = 1'b0;
      end
    end
    @(negedge clk);
    cz = 1'b0;
  endtask

  task automatic raw(logic va, logic vb, int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      a = va; b = vb; cz = 1'b0; gs = 1'b0; wr_en = 1'b0;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    tests++; fails++;
    $display("[TB] FAIL watchdog expired during %s", phase);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    // R11: outputs low under reset even with the low-side source high.
    b = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check(oh === 1'b0 && ol === 1'b0, "R11", "outputs in reset", int'({oh, ol}), 0);
    end
    @(negedge clk);
    rst_n = 1'b1; b = 1'b0;

    phase = "R8 pass-through while disabled";
    period(5, 3, 2);
    raw(1'b1, 1'b1, 3);
    raw(1'b0, 1'b0, 2);
    raw(1'b1, 1'b0, 2);

    phase = "R5 R3 immediate writes";
    mode = 2'd0;
    reg_wr(2'd1, 3);
    reg_wr(2'd2, 5);
    reg_wr(2'd3, 9);
    reg_wr(2'd0, 1);
    phase = "R1 R2 R3 unequal delays";
    period(12, 10, 3);
    phase = "R1 R2 zero delays";
    reg_wr(2'd1, 0);
    reg_wr(2'd2, 0);
    period(6, 6, 2);

    phase = "R10 short pulses";
    reg_wr(2'd1, 4);
    reg_wr(2'd2, 4);
    period(4, 4, 2);
    period(3, 2, 2);
    period(5, 6, 2);

    phase = "R5 local update";
    mode = 2'd1;
    period(8, 8, 1);
    reg_wr(2'd1, 1);
    raw(1'b1, 1'b0, 6);
    period(8, 8, 2);

    phase = "R7 overwrite before apply";
    reg_wr(2'd2, 7);
    reg_wr(2'd2, 2);
    period(8, 8, 2);

    phase = "R6 global update waits for sync";
    mode = 2'd2;
    reg_wr(2'd1, 6);
    period(9, 9, 2);
    sync_pulse();
    period(9, 9, 2);

    phase = "R9 latch cleared after use";
    reg_wr(2'd2, 6);
    period(9, 9, 2);
    sync_pulse();
    period(9, 9, 1);

    phase = "R6 R8 global disable";
    mode = 2'd3;
    reg_wr(2'd0, 0);
    period(7, 5, 1);
    sync_pulse();
    period(7, 5, 1);
    raw(1'b1, 1'b1, 2);

    raw(1'b0, 1'b0, 3);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule